// File: doc/BRIEF.md
# Two-Path Intersection Light Sequencer

This block sequences the vehicle and pedestrian lights of an intersection with two crossing paths (path 0 and path 1). Each path has four vehicle lamps (green, yellow, left-turn arrow, red), and each path's road has a pedestrian walk signal. All timing is counted in 100 ms ticks taken from a one-cycle clock-enable input. Nothing in the block advances on a clock edge without a tick, except the return to the stopped state when `start` falls.

The normal cycle runs the two paths in complement. Two override modes sit on top of it. The priority request gives one chosen path a steady green, and it outranks everything else. The night request drops the pedestrian signals and hands green to the paths that the two camera bits report as occupied. Entering or leaving either mode passes through a 1 s all-yellow window. Entry waits while a pedestrian crossing is running. When the priority mode ends in the middle of a left-turn phase, the block either continues the arrow or drops the path to red, depending on how long the arrow had already run.

Top module: `xing_sequencer`

## Requirements
- R1: In normal running, path 0 shows green for 100 ticks, yellow 10, left arrow 50, yellow 10, then red 170, over a 340-tick cycle position t. Path 1 shows the same pattern shifted by 170 ticks. Exactly one lamp of each path is lit in every cycle.
- R2: `ped_walk[p]` is high only in normal running, and only while the other path shows green. It is low in every other mode.
- R3: While `rst_n` is low, or in the cycle after `start` is seen low, both paths show red and both walk signals are low. The first tick with `start` high begins normal running at t = 0 (path 0 green).
- R4: A mode request seen on a tick in normal running is acted on only when no walk signal is high. Acting on it freezes t and shows yellow on both paths for 10 ticks before the mode begins.
- R5: In priority mode the path selected by `vip_sel` (0 or 1, followed live) shows green and the other shows red. `night_req` has no effect while priority mode is active.
- R6: When both requests are present at entry, the block goes to priority mode. A priority request during night mode leads through a 10-tick all-yellow window into priority mode.
- R7: Leaving a mode (the request seen low on a tick) shows yellow on both paths for 10 ticks. Normal running then resumes at the frozen t.
- R8: If the excursion included priority mode and the frozen t lies in a path's left-arrow phase, the resume point depends on the ticks the arrow had already run. At 35 or fewer, t resumes unchanged. At 36 or more, t jumps to the start of that path's red (t = 170 for path 0, t = 0 for path 1).
- R9: In night mode, with `cam` = 01 path 0 is green and path 1 red; with 10 path 1 is green and path 0 red; with 00 both are red (bit p reports a vehicle waiting on path p).
- R10: In night mode with `cam` = 11, green stays on the path that held it last (path 0 if none did). It swaps to the other path every 100 ticks.
- R11: With `tick` low and `start` high, no light or walk output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | 100 ms clock enable |
| start | input | 1 | Run enable; low holds all red |
| vip_req | input | 1 | Priority-mode request |
| vip_sel | input | 1 | Path given green in priority mode |
| night_req | input | 1 | Night-mode request |
| cam | input | 2 | Per-path vehicle-waiting bits |
| veh_grn | output | 2 | Green lamp per path |
| veh_yel | output | 2 | Yellow lamp per path |
| veh_lft | output | 2 | Left-arrow lamp per path |
| veh_red | output | 2 | Red lamp per path |
| ped_walk | output | 2 | Walk signal per path's road |

## Verification
The bench times a priority request against the reference model so that the frozen left arrow has run exactly 35 and then exactly 36 ticks. A design that compared at the wrong side of the boundary would then show the arrow where red is due, or the reverse. Requests raised during a walk window catch a block that cuts a crossing short by going yellow at once. Camera patterns in night mode catch a swap that comes a tick early, or that starts on the wrong path. Windows with `tick` held low, and with sparse ticks, catch logic that advances on the clock rather than on the enable.

// File: rtl/xs_pkg.sv
package xs_pkg;

  typedef enum logic [2:0] {
    M_IDLE, M_NORM, M_ENT, M_VIP, M_NIGHT, M_EXT
  } mode_e;

  typedef logic [1:0] lamp_t;
  localparam lamp_t LP_RED = 2'd0;
  localparam lamp_t LP_GRN = 2'd1;
  localparam lamp_t LP_YEL = 2'd2;
  localparam lamp_t LP_LFT = 2'd3;

  // Lamp of a path whose own phase offset is u ticks into its sequence.
  function automatic lamp_t lamp_at(int u, int g, int y, int l);
    if (u < g)               return LP_GRN;
    else if (u < g + y)      return LP_YEL;
    else if (u < g + y + l)  return LP_LFT;
    else if (u < g + 2*y + l) return LP_YEL;
    else                     return LP_RED;
  endfunction

  // Resume position after an override; arrow skip only after priority mode.
  function automatic int resume_at(int t, int half, int g, int y, int l,
                                   int roll, bit was_vip);
    int ls;
    for (int p = 0; p < 2; p++) begin
      ls = p * half + g + y;
      if (was_vip && t >= ls && t < ls + l && (t - ls) > roll)
        return (p == 0) ? half : 0;
    end
    return t;
  endfunction

endpackage

// File: rtl/xs_cycle_lights.sv
module xs_cycle_lights #(
  parameter int GRN_T = 100,
  parameter int YEL_T = 10,
  parameter int LFT_T = 50,
  parameter int TW    = 9
) (
  input  logic [TW-1:0]   t,
  output xs_pkg::lamp_t   lamp0,
  output xs_pkg::lamp_t   lamp1,
  output logic [1:0]      walk
);
  import xs_pkg::*;

  localparam int HALF = GRN_T + 2*YEL_T + LFT_T;
  localparam int CYC  = 2 * HALF;

  lamp_t lamp [2];

  for (genvar p = 0; p < 2; p++) begin : g_path
    int u;
    always_comb begin
      u       = (int'(t) + CYC - p * HALF) % CYC;
      lamp[p] = lamp_at(u, GRN_T, YEL_T, LFT_T);
    end
  end

  assign lamp0   = lamp[0];
  assign lamp1   = lamp[1];
  assign walk[0] = (lamp[1] == LP_GRN);
  assign walk[1] = (lamp[0] == LP_GRN);

endmodule

// File: rtl/xs_night_grant.sv
module xs_night_grant #(
  parameter int ALT_T = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       active,
  input  logic [1:0] cam,
  output logic [1:0] grant
);
  localparam int CW = $clog2(ALT_T + 1);

  logic          owner;
  logic [CW-1:0] cnt;
  logic          swap_due;

  assign swap_due = (cam == 2'b11) && (cnt == CW'(ALT_T - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner <= 1'b0;
      cnt   <= '0;
    end else if (!active) begin
      owner <= 1'b0;
      cnt   <= '0;
    end else if (tick) begin
      if (cam == 2'b11) begin
        if (swap_due) begin
          owner <= ~owner;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt   <= '0;
        owner <= (cam == 2'b10);
      end
    end
  end

  assign grant = (cam == 2'b11) ? (owner ? 2'b10 : 2'b01) : cam;

  a_r9_grant_needs_car: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~cam) == 2'b00);
  a_r10_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= 1);
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(ALT_T));

endmodule

// File: rtl/xs_mode_fsm.sv
module xs_mode_fsm #(
  parameter int GRN_T  = 100,
  parameter int YEL_T  = 10,
  parameter int LFT_T  = 50,
  parameter int ROLL_T = 35,
  parameter int XFER_T = 10,
  parameter int TW     = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          vip_req,
  input  logic          night_req,
  input  logic          walk_any,
  output xs_pkg::mode_e mode,
  output logic [TW-1:0] t
);
  import xs_pkg::*;

  localparam int HALF = GRN_T + 2*YEL_T + LFT_T;
  localparam int CYC  = 2 * HALF;
  localparam int KW   = $clog2(XFER_T + 1);

  mode_e         tgt;
  logic [KW-1:0] k;
  logic          was_vip;
  logic          xfer_done;
  logic          enter_ok;
  logic [TW-1:0] t_resume;

  assign xfer_done = (k == KW'(XFER_T - 1));
  assign enter_ok  = (vip_req || night_req) && !walk_any;
  assign t_resume  = TW'(resume_at(int'(t), HALF, GRN_T, YEL_T, LFT_T,
                                   ROLL_T, was_vip));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_IDLE; tgt <= M_NIGHT; t <= '0; k <= '0; was_vip <= 1'b0;
    end else if (!start) begin
      mode <= M_IDLE; t <= '0; k <= '0; was_vip <= 1'b0;
    end else if (tick) begin
      case (mode)
        M_IDLE: begin
          mode <= M_NORM;
          t    <= '0;
        end
        M_NORM: begin
          if (enter_ok) begin
            mode <= M_ENT;
            tgt  <= vip_req ? M_VIP : M_NIGHT;
            k    <= '0;
          end else begin
            t <= (t == TW'(CYC - 1)) ? '0 : t + 1'b1;
          end
        end
        M_ENT: begin
          if (xfer_done) begin
            mode <= tgt;
            k    <= '0;
            if (tgt == M_VIP) was_vip <= 1'b1;
          end else k <= k + 1'b1;
        end
        M_VIP: begin
          if (!vip_req) begin mode <= M_EXT; k <= '0; end
        end
        M_NIGHT: begin
          if (vip_req) begin
            mode <= M_ENT; tgt <= M_VIP; k <= '0;
          end else if (!night_req) begin
            mode <= M_EXT; k <= '0;
          end
        end
        M_EXT: begin
          if (xfer_done) begin
            mode <= M_NORM; k <= '0; was_vip <= 1'b0; t <= t_resume;
          end else k <= k + 1'b1;
        end
        default: mode <= M_IDLE;
      endcase
    end
  end

  a_r11_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && start) |=> ($stable(mode) && $stable(t)));
  a_r4_defer_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORM && walk_any) |=> (mode != M_ENT));
  a_r7_xfer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    k < KW'(XFER_T));
  a_r1_t_range: assert property (@(posedge clk) disable iff (!rst_n)
    t < TW'(CYC));

endmodule

// File: rtl/xing_sequencer.sv
module xing_sequencer #(
  parameter int GRN_T  = 100,
  parameter int YEL_T  = 10,
  parameter int LFT_T  = 50,
  parameter int ROLL_T = 35,
  parameter int XFER_T = 10,
  parameter int ALT_T  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic       vip_req,
  input  logic       vip_sel,
  input  logic       night_req,
  input  logic [1:0] cam,
  output logic [1:0] veh_grn,
  output logic [1:0] veh_yel,
  output logic [1:0] veh_lft,
  output logic [1:0] veh_red,
  output logic [1:0] ped_walk
);
  import xs_pkg::*;

  localparam int HALF = GRN_T + 2*YEL_T + LFT_T;
  localparam int CYC  = 2 * HALF;
  localparam int TW   = $clog2(CYC);

  mode_e         mode;
  logic [TW-1:0] t;
  lamp_t         cyc_lamp0, cyc_lamp1;
  logic [1:0]    cyc_walk;
  logic [1:0]    grant;
  logic          walk_any;
  lamp_t         cyc_lamp [2];
  lamp_t         lamp [2];

  xs_cycle_lights #(.GRN_T(GRN_T), .YEL_T(YEL_T), .LFT_T(LFT_T), .TW(TW)) u_cycle (
    .t(t), .lamp0(cyc_lamp0), .lamp1(cyc_lamp1), .walk(cyc_walk));

  assign walk_any = |cyc_walk;

  xs_mode_fsm #(.GRN_T(GRN_T), .YEL_T(YEL_T), .LFT_T(LFT_T), .ROLL_T(ROLL_T),
                .XFER_T(XFER_T), .TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .vip_req(vip_req),
    .night_req(night_req), .walk_any(walk_any), .mode(mode), .t(t));

  xs_night_grant #(.ALT_T(ALT_T)) u_night (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(mode == M_NIGHT),
    .cam(cam), .grant(grant));

  assign cyc_lamp[0] = cyc_lamp0;
  assign cyc_lamp[1] = cyc_lamp1;

  for (genvar p = 0; p < 2; p++) begin : g_out
    always_comb begin
      case (mode)
        M_NORM:          lamp[p] = cyc_lamp[p];
        M_ENT, M_EXT:    lamp[p] = LP_YEL;
        M_VIP:           lamp[p] = (vip_sel == 1'(p)) ? LP_GRN : LP_RED;
        M_NIGHT:         lamp[p] = grant[p] ? LP_GRN : LP_RED;
        default:         lamp[p] = LP_RED;
      endcase
    end
    assign veh_grn[p]  = (lamp[p] == LP_GRN);
    assign veh_yel[p]  = (lamp[p] == LP_YEL);
    assign veh_lft[p]  = (lamp[p] == LP_LFT);
    assign veh_red[p]  = (lamp[p] == LP_RED);
    assign ped_walk[p] = (mode == M_NORM) && cyc_walk[p];

    a_r1_one_lamp: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({veh_grn[p], veh_yel[p], veh_lft[p], veh_red[p]}) == 1);
    a_r2_walk_safe: assert property (@(posedge clk) disable iff (!rst_n)
      ped_walk[p] |-> (veh_red[p] && veh_grn[1-p]));
  end

  a_r3_stop_red: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (veh_red == 2'b11 && ped_walk == 2'b00));
  a_r5_vip_green: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_VIP) |-> (veh_grn[vip_sel] && veh_red[!vip_sel]));
  a_r2_walk_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_NORM) |-> (ped_walk == 2'b00));

endmodule

// File: tb/xing_sequencer_tb.sv
module xing_sequencer_tb;
  logic clk = 0, rst_n = 0, tick = 0, start = 0;
  logic vip_req = 0, vip_sel = 0, night_req = 0;
  logic [1:0] cam = 0;
  logic [1:0] veh_grn, veh_yel, veh_lft, veh_red, ped_walk;

  always #5 clk = ~clk;

  xing_sequencer u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .vip_req(vip_req), .vip_sel(vip_sel), .night_req(night_req), .cam(cam),
    .veh_grn(veh_grn), .veh_yel(veh_yel), .veh_lft(veh_lft), .veh_red(veh_red),
    .ped_walk(ped_walk));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // Reference model: 0 stop,1 normal,2 entry,3 priority,4 night,5 exit
  int m_mode = 0, m_t = 0, m_k = 0, m_tgt = 4, m_vs = 0, m_own = 0, m_nc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_t = 0; m_k = 0; m_vs = 0; m_own = 0; m_nc = 0; m_tgt = 4;
    end else begin
      if (m_mode != 4) begin m_own = 0; m_nc = 0; end
      else if (tick) begin
        if (cam == 2'b11) begin
          m_nc++;
          if (m_nc == 100) begin m_own = 1 - m_own; m_nc = 0; end
        end else begin m_nc = 0; m_own = (cam == 2'b10) ? 1 : 0; end
      end
      if (!start) begin m_mode = 0; m_t = 0; m_k = 0; m_vs = 0; end
      else if (tick) begin
        case (m_mode)
          0: begin m_mode = 1; m_t = 0; end
          1: if ((vip_req || night_req) && model_walk() == 0) begin
               m_mode = 2; m_tgt = vip_req ? 3 : 4; m_k = 0;
             end else m_t = (m_t + 1) % 340;
          2: begin m_k++; if (m_k == 10) begin m_mode = m_tgt; m_k = 0;
               if (m_tgt == 3) m_vs = 1; end end
          3: if (!vip_req) begin m_mode = 5; m_k = 0; end
          4: if (vip_req) begin m_mode = 2; m_tgt = 3; m_k = 0; end
             else if (!night_req) begin m_mode = 5; m_k = 0; end
          5: begin m_k++; if (m_k == 10) begin
               m_mode = 1; m_k = 0;
               if (m_vs != 0) begin
                 if (m_t >= 146 && m_t < 160) m_t = 170;
                 else if (m_t >= 316 && m_t < 330) m_t = 0;
               end
               m_vs = 0; end end
          default: ;
        endcase
      end
    end
  end

  // 0 red, 1 green, 2 yellow, 3 arrow for path p in normal running
  function automatic int norm_lamp(int p);
    int u = (m_t - 170 * p + 340) % 340;
    if (u < 100) return 1;
    if (u < 110) return 2;
    if (u < 160) return 3;
    if (u < 170) return 2;
    return 0;
  endfunction

  function automatic int model_walk();
    return (norm_lamp(1) == 1 ? 1 : 0) + (norm_lamp(0) == 1 ? 2 : 0);
  endfunction

  function automatic int exp_lamp(int p);
    case (m_mode)
      1: return norm_lamp(p);
      2, 5: return 2;
      3: return (vip_sel == p[0]) ? 1 : 0;
      4: begin
        if (cam == 2'b11) return (m_own == p) ? 1 : 0;
        return cam[p] ? 1 : 0;
      end
      default: return 0;
    endcase
  endfunction

  function automatic logic [9:0] expected();
    logic [1:0] g, y, l, r, w;
    for (int p = 0; p < 2; p++) begin
      g[p] = exp_lamp(p) == 1; y[p] = exp_lamp(p) == 2;
      l[p] = exp_lamp(p) == 3; r[p] = exp_lamp(p) == 0;
    end
    w = (m_mode == 1) ? 2'(model_walk()) : 2'b00;
    return {g, y, l, r, w};
  endfunction

  function automatic string tag_of();
    case (m_mode)
      1: return "R1/R2";
      2: return "R4";
      3: return "R5";
      4: return "R9";
      5: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [9:0] outs();
    return {veh_grn, veh_yel, veh_lft, veh_red, ped_walk};
  endfunction

  // Model compare on every clock, away from the edge
  always @(negedge clk) if (rst_n && !done) check(tag_of(), outs(), expected());

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_norm_t(int tv);
    do @(negedge clk); while (!(m_mode == 1 && m_t == tv));
  endtask

  task automatic wait_mode(int md);
    do @(negedge clk); while (m_mode != md);
  endtask

  logic [9:0] held;

  initial begin
    cycles(4);
    check("R3 reset", outs(), {2'b00, 2'b00, 2'b00, 2'b11, 2'b00});
    rst_n = 1; tick = 1;
    cycles(3);
    check("R3 stopped", outs(), {2'b00, 2'b00, 2'b00, 2'b11, 2'b00});
    start = 1;
    cycles(1);
    cycles(1);
    // R3: first tick with start: path 0 green; R2: walk on path 1 road
    check("R3 start green", outs(), {2'b01, 2'b00, 2'b00, 2'b10, 2'b10});
    cycles(700);

    // R4: request during walk is deferred
    wait_norm_t(20);
    vip_req = 1; vip_sel = 1;
    cycles(2);
    check("R4 deferred", {veh_grn, ped_walk}, {2'b01, 2'b10});
    wait_mode(3);
    night_req = 1;             // R5: ignored in priority mode
    cycles(20); vip_sel = 0; cycles(20);
    vip_req = 0; night_req = 0;
    wait_mode(1);

    // R8: arrow ran 35 ticks -> resumes
    wait_norm_t(145);
    vip_req = 1; vip_sel = 1;
    wait_mode(3); cycles(5); vip_req = 0;
    wait_mode(1);
    check("R8 rollback", {veh_lft, veh_red}, {2'b01, 2'b10});
    // R8: arrow ran 36 ticks -> straight to red
    wait_norm_t(146);
    vip_req = 1;
    wait_mode(3); cycles(5); vip_req = 0;
    wait_mode(1);
    check("R8 skip", {veh_grn, veh_red}, {2'b10, 2'b01});
    cycles(400);

    // R6: both requests at once go to priority mode
    wait_norm_t(105);
    vip_req = 1; night_req = 1; vip_sel = 0;
    wait_mode(3);
    check("R6 priority wins", {veh_grn, veh_red}, {2'b01, 2'b10});
    vip_req = 0;
    wait_mode(4);
    cam = 2'b00; cycles(3);
    check("R9 empty", {veh_grn, veh_red, ped_walk}, {2'b00, 2'b11, 2'b00});
    cam = 2'b01; cycles(3);
    check("R9 path0", {veh_grn, veh_red}, {2'b01, 2'b10});
    cam = 2'b10; cycles(3);
    check("R9 path1", {veh_grn, veh_red}, {2'b10, 2'b01});
    cam = 2'b11; cycles(50);
    check("R10 hold", {8'b0, veh_grn}, {8'b0, 2'b10});
    cycles(100);
    check("R10 swap", {8'b0, veh_grn}, {8'b0, 2'b01});
    cycles(250);
    // R6: priority request interrupts night
    vip_req = 1; vip_sel = 1;
    wait_mode(3);
    check("R6 from night", {veh_grn, veh_red}, {2'b10, 2'b01});
    vip_req = 0; night_req = 0; cam = 2'b00;
    wait_mode(1);
    cycles(50);

    // R11: no tick, no change
    tick = 0; cycles(1); held = outs();
    cycles(40);
    check("R11 hold", outs(), held);
    for (int i = 0; i < 600; i++) begin
      tick = (i % 3 == 0); cycles(1);
    end
    tick = 1;
    // R3: dropping start returns to red
    start = 0; cycles(2);
    check("R3 stop", outs(), {2'b00, 2'b00, 2'b00, 2'b11, 2'b00});
    start = 1; cycles(400);
    finish_run();
  end
endmodule